// File: doc/BRIEF.md
# Virtual Address Translation Checker

This block sits between an address generator and a separate translation buffer. It takes one virtual address per cycle and returns a registered verdict one cycle later. The verdict is either a physical address or a ranked fault code. The translation buffer is looked up in the same cycle as the request and returns a hit flag, a page frame number and a permission vector. Table walking and entry storage belong to other blocks.

Each request passes through a fixed sequence of checks:

1. The bits above the implemented address range are screened for a proper sign extension.
2. Two fixed-pattern direct-map windows are matched. These windows are usable only in kernel mode.
3. If neither of the above settles the request, the translation buffer result decides. A miss is a fault. On a hit, the block compares the permissions the request needs with those the entry grants, and the shortfall is ranked into a single fault code.

Every response also reports the kind of access: read, write or execute.

Top module: `xlate_front`

## Requirements
- R1: A request whose address bits 63..43 are neither all zeros nor all ones gets fault code 1 (bad address) and a zero address. This check ranks above every other check.
- R2: When window enable bit 1 is set, address bits 42..41 equal 2'b10 and the mode is 0 (kernel), the result is fault 0 with address bits 40..0 passed through. The translation buffer response is ignored.
- R3: When window enable bit 0 is set, address bits 42..30 equal 13'h1FFE and the mode is 0, the result is fault 0 with address bits 29..0 passed through and the upper bits zero.
- R4: An enabled window match in any mode other than 0 gives fault code 2 (access violation) and a zero address.
- R5: An address inside a window pattern whose enable bit is clear is treated as an ordinary address and sent to the translation buffer.
- R6: An ordinary address with the buffer hit flag low gives fault code 4 (buffer miss).
- R7: On a hit, the needed permission bits that the entry lacks are ranked in this order:
  - any missing bit among 11..4 (read enables by mode at 4+mode, write enables at 8+mode) gives code 2;
  - otherwise any missing bit among 3..1 (no-fault execute, write, read) gives code 3 (fault-on-access);
  - otherwise a missing bit 0 (valid) gives code 5 (not valid).
- R8: For an instruction fetch, the needed set is bit 0, bit 3 and bit 4+mode, and the data need input is ignored. For data, the need input is used as given.
- R9: The kind output is 2'b11 for a fetch. For data it is 2'b10 when need bit 2 is set and 2'b01 otherwise. The kind is reported for successes and faults alike.
- R10: On a hit with every needed bit granted, the result is fault 0. The address is the page frame number concatenated with address bits 12..0.
- R11: The response strobe is high exactly one cycle after each request strobe and low otherwise. After reset, the strobe, the fault, the kind and the address are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data |
| req_va | input | 64 | Virtual address |
| req_need | input | 12 | Needed permission bits for data |
| cur_mode | input | 2 | Current mode, 0 = kernel |
| win_en | input | 2 | Window enables (bit 1: large window, bit 0: small window) |
| tb_hit | input | 1 | Translation buffer hit |
| tb_pfn | input | 28 | Page frame number from the buffer |
| tb_perm | input | 12 | Permissions granted by the buffer entry |
| rsp_vld | output | 1 | Response strobe |
| rsp_fault | output | 3 | Fault code, 0 = success |
| rsp_kind | output | 2 | Access kind: 01 read, 10 write, 11 execute |
| rsp_pa | output | 41 | Physical address, zero on a fault |

## Verification
The stimulus covers several address classes:
- malformed upper bits, which separate the sign screen from everything after it;
- addresses in each window with the enable set and with it clear, in kernel and non-kernel modes, which distinguish a window pass-through from a privilege fault and from a plain buffer lookup;
- ordinary addresses with a miss, with full permissions, and with permissions that have exactly one class of bit removed.

Removing one class of bit at a time shows whether the ranking orders violation, fault-on-access and not-valid correctly. Fetches and data writes with deliberately conflicting need inputs show whether the needed set and the kind come from the right source. Idle gaps between requests check that the strobe is one-for-one.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_BADVA = 3'd1,
        FLT_ACV   = 3'd2,
        FLT_FOA   = 3'd3,
        FLT_MISS  = 3'd4,
        FLT_TNV   = 3'd5
    } fault_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_RD   = 2'd1,
        KIND_WR   = 2'd2,
        KIND_EX   = 2'd3
    } kind_e;

    // permission vector layout (a granted bit is 1)
    localparam int PERM_W   = 12;
    localparam int PB_VALID = 0;
    localparam int PB_NF_RD = 1;
    localparam int PB_NF_WR = 2;
    localparam int PB_NF_EX = 3;
    localparam int PB_RDEN  = 4;   // + mode
    localparam int PB_WREN  = 8;   // + mode

endpackage

// File: rtl/xlate_va_screen.sv
module xlate_va_screen #(
    parameter int VA_W      = 64,
    parameter int IMPL_W    = 43,
    parameter int PA_W      = 41,
    parameter int WA_SEL_W  = 2,
    parameter int WA_SEL    = 2,
    parameter int WA_PA_W   = 41,
    parameter int WB_SEL_W  = 13,
    parameter int WB_SEL    = 13'h1FFE,
    parameter int WB_PA_W   = 30
) (
    input  logic [VA_W-1:0] va,
    input  logic [1:0]      win_en,
    output logic            sign_ok,
    output logic            win_hit,
    output logic [PA_W-1:0] win_pa
);
    localparam int EXT_W = VA_W - IMPL_W;

    logic [EXT_W-1:0] ext;
    logic             hit_a;
    logic             hit_b;

    always_comb begin
        ext     = va[VA_W-1:IMPL_W];
        sign_ok = (ext == '0) || (ext == '1);
        hit_a   = win_en[1] && (va[IMPL_W-1 -: WA_SEL_W] == WA_SEL_W'(WA_SEL));
        hit_b   = win_en[0] && (va[IMPL_W-1 -: WB_SEL_W] == WB_SEL_W'(WB_SEL));
        win_hit = hit_a || hit_b;
        win_pa  = '0;
        if (hit_a) begin
            win_pa[WA_PA_W-1:0] = va[WA_PA_W-1:0];
        end else if (hit_b) begin
            win_pa[WB_PA_W-1:0] = va[WB_PA_W-1:0];
        end
    end

endmodule

// File: rtl/xlate_perm_rank.sv
module xlate_perm_rank
    import xlate_pkg::*;
(
    input  logic [PERM_W-1:0] need,
    input  logic [PERM_W-1:0] have,
    output fault_e            fault
);
    localparam logic [PERM_W-1:0] FO_MASK =
        PERM_W'((1 << PB_NF_RD) | (1 << PB_NF_WR) | (1 << PB_NF_EX));
    localparam logic [PERM_W-1:0] V_MASK  = PERM_W'(1 << PB_VALID);
    localparam logic [PERM_W-1:0] EN_MASK = ~(FO_MASK | V_MASK);

    logic [PERM_W-1:0] short_bits;

    always_comb begin
        short_bits = need & ~have;
        if (|(short_bits & EN_MASK)) begin
            fault = FLT_ACV;
        end else if (|(short_bits & FO_MASK)) begin
            fault = FLT_FOA;
        end else if (|(short_bits & V_MASK)) begin
            fault = FLT_TNV;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/xlate_front.sv
module xlate_front
    import xlate_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int IMPL_W   = 43,
    parameter int PAGE_W   = 13,
    parameter int PFN_W    = 28,
    parameter int MODE_W   = 2,
    parameter int WA_SEL_W = 2,
    parameter int WA_SEL   = 2,
    parameter int WA_PA_W  = 41,
    parameter int WB_SEL_W = 13,
    parameter int WB_SEL   = 13'h1FFE,
    parameter int WB_PA_W  = 30,
    localparam int PA_W    = PFN_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic              req_fetch,
    input  logic [VA_W-1:0]   req_va,
    input  logic [PERM_W-1:0] req_need,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [1:0]        win_en,
    input  logic              tb_hit,
    input  logic [PFN_W-1:0]  tb_pfn,
    input  logic [PERM_W-1:0] tb_perm,
    output logic              rsp_vld,
    output logic [2:0]        rsp_fault,
    output logic [1:0]        rsp_kind,
    output logic [PA_W-1:0]   rsp_pa
);
    typedef struct packed {
        logic            vld;
        fault_e          fault;
        kind_e           kind;
        logic [PA_W-1:0] pa;
    } rsp_t;

    rsp_t              r_d, r_q;
    logic              sign_ok;
    logic              win_hit;
    logic [PA_W-1:0]   win_pa;
    logic [PERM_W-1:0] need_eff;
    fault_e            perm_fault;

    xlate_va_screen #(
        .VA_W(VA_W), .IMPL_W(IMPL_W), .PA_W(PA_W),
        .WA_SEL_W(WA_SEL_W), .WA_SEL(WA_SEL), .WA_PA_W(WA_PA_W),
        .WB_SEL_W(WB_SEL_W), .WB_SEL(WB_SEL), .WB_PA_W(WB_PA_W)
    ) i_screen (
        .va(req_va), .win_en(win_en),
        .sign_ok(sign_ok), .win_hit(win_hit), .win_pa(win_pa)
    );

    always_comb begin
        if (req_fetch) begin
            need_eff = '0;
            need_eff[PB_VALID] = 1'b1;
            need_eff[PB_NF_EX] = 1'b1;
            need_eff[PB_RDEN + int'(cur_mode)] = 1'b1;
        end else begin
            need_eff = req_need;
        end
    end

    xlate_perm_rank i_rank (
        .need(need_eff), .have(tb_perm), .fault(perm_fault)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = req_vld;
        if (req_vld) begin
            if (req_fetch)                r_d.kind = KIND_EX;
            else if (req_need[PB_NF_WR])  r_d.kind = KIND_WR;
            else                          r_d.kind = KIND_RD;
            r_d.pa = '0;
            if (!sign_ok) begin
                r_d.fault = FLT_BADVA;
            end else if (win_hit) begin
                if (cur_mode != '0) begin
                    r_d.fault = FLT_ACV;
                end else begin
                    r_d.fault = FLT_NONE;
                    r_d.pa    = win_pa;
                end
            end else if (!tb_hit) begin
                r_d.fault = FLT_MISS;
            end else begin
                r_d.fault = perm_fault;
                if (perm_fault == FLT_NONE) begin
                    r_d.pa = {tb_pfn, req_va[PAGE_W-1:0]};
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{vld: 1'b0, fault: FLT_NONE, kind: KIND_NONE, pa: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_vld   = r_q.vld;
    assign rsp_fault = r_q.fault;
    assign rsp_kind  = r_q.kind;
    assign rsp_pa    = r_q.pa;

endmodule

// File: rtl/xlate_front_chk.sv
module xlate_front_chk #(
    parameter int VA_W     = 64,
    parameter int IMPL_W   = 43,
    parameter int MODE_W   = 2,
    parameter int WA_SEL_W = 2,
    parameter int WA_SEL   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_vld,
    input logic              req_fetch,
    input logic [VA_W-1:0]   req_va,
    input logic [MODE_W-1:0] cur_mode,
    input logic [1:0]        win_en,
    input logic              tb_hit,
    input logic              rsp_vld,
    input logic [2:0]        rsp_fault,
    input logic [1:0]        rsp_kind
);
    logic upper_zero, upper_ones, big_win;

    always_comb begin
        upper_zero = ~|req_va[VA_W-1:IMPL_W];
        upper_ones = &req_va[VA_W-1:IMPL_W];
        big_win    = win_en[1] && (req_va[IMPL_W-1 -: WA_SEL_W] == WA_SEL_W'(WA_SEL));
    end

    a_r1_bad_sign: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && !upper_zero && !upper_ones |=> rsp_fault == 3'd1);

    a_r4_window_user: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && (upper_zero || upper_ones) && big_win && cur_mode != '0
        |=> rsp_fault == 3'd2);

    a_r2_window_kernel: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && (upper_zero || upper_ones) && big_win && cur_mode == '0
        |=> rsp_fault == 3'd0);

    a_r9_fetch_exec: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && req_fetch |=> rsp_kind == 2'b11);

    a_r11_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld);

    a_r6_miss_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld && rsp_fault == 3'd4 |-> $past(!tb_hit));

endmodule

bind xlate_front xlate_front_chk #(
    .VA_W(VA_W), .IMPL_W(IMPL_W), .MODE_W(MODE_W),
    .WA_SEL_W(WA_SEL_W), .WA_SEL(WA_SEL)
) i_chk (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_fetch(req_fetch),
    .req_va(req_va), .cur_mode(cur_mode), .win_en(win_en), .tb_hit(tb_hit),
    .rsp_vld(rsp_vld), .rsp_fault(rsp_fault), .rsp_kind(rsp_kind)
);

// File: tb/test_xlate_front.sv
`timescale 1ns/1ps
module test_xlate_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic        req_fetch = 1'b0;
    logic [63:0] req_va = '0;
    logic [11:0] req_need = '0;
    logic [1:0]  cur_mode = '0;
    logic [1:0]  win_en = '0;
    logic        tb_hit = 1'b0;
    logic [27:0] tb_pfn = '0;
    logic [11:0] tb_perm = '0;
    logic        rsp_vld;
    logic [2:0]  rsp_fault;
    logic [1:0]  rsp_kind;
    logic [40:0] rsp_pa;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    xlate_front i_xlate_front (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_fetch(req_fetch),
        .req_va(req_va), .req_need(req_need), .cur_mode(cur_mode),
        .win_en(win_en), .tb_hit(tb_hit), .tb_pfn(tb_pfn), .tb_perm(tb_perm),
        .rsp_vld(rsp_vld), .rsp_fault(rsp_fault), .rsp_kind(rsp_kind),
        .rsp_pa(rsp_pa)
    );

    // behavioural reference: returns fault, kind, address and a requirement tag
    function automatic void model(input bit fetch, input logic [63:0] va,
                                  input logic [11:0] need, input int mode,
                                  input logic [1:0] en, input bit hit,
                                  input logic [27:0] pfn, input logic [11:0] perm,
                                  output int f, output int k,
                                  output logic [40:0] pa, output string tag);
        longint unsigned top21;
        int nd, miss;
        top21 = va >> 43;
        pa = '0;
        if (fetch) k = 3; else if (need[2]) k = 2; else k = 1;
        if (top21 != 0 && top21 != 64'h1F_FFFF) begin
            f = 1; tag = "R1"; return;
        end
        if (en[1] && ((va >> 41) & 3) == 2) begin
            if (mode != 0) begin f = 2; tag = "R4"; return; end
            f = 0; tag = "R2"; pa = va[40:0]; return;
        end
        if (en[0] && ((va >> 30) & 64'h1FFF) == 64'h1FFE) begin
            if (mode != 0) begin f = 2; tag = "R4"; return; end
            f = 0; tag = "R3"; pa = 41'(va % (64'd1 << 30)); return;
        end
        if (!hit) begin f = 4; tag = "R6"; return; end
        nd = fetch ? (1 + 8 + (1 << (4 + mode))) : int'(need);
        miss = nd & ~int'(perm);
        if ((miss & 12'hFF0) != 0)      begin f = 2; tag = "R7"; end
        else if ((miss & 12'h00E) != 0) begin f = 3; tag = "R7"; end
        else if ((miss & 1) != 0)       begin f = 5; tag = "R7"; end
        else begin
            f = 0; tag = "R10";
            pa = {pfn, va[12:0]};
        end
    endfunction

    task automatic step(input bit v, input bit fetch, input logic [63:0] va,
                        input logic [11:0] need, input logic [1:0] mode,
                        input logic [1:0] en, input bit hit,
                        input logic [27:0] pfn, input logic [11:0] perm,
                        input string extra);
        int ef, ek;
        logic [40:0] epa;
        string tag;
        req_vld = v; req_fetch = fetch; req_va = va; req_need = need;
        cur_mode = mode; win_en = en; tb_hit = hit; tb_pfn = pfn; tb_perm = perm;
        model(fetch, va, need, int'(mode), en, hit, pfn, perm, ef, ek, epa, tag);
        @(posedge clk);
        #1;
        total++;
        if (!v) begin
            if (rsp_vld !== 1'b0) begin
                bad++;
                $display("FAIL R11 idle: rsp_vld=%b expected 0", rsp_vld);
            end
        end else if (rsp_vld !== 1'b1 || rsp_fault !== 3'(ef) ||
                     rsp_kind !== 2'(ek) || rsp_pa !== epa) begin
            bad++;
            $display("FAIL %s %s R9 R11: vld=%b fault=%0d kind=%0d pa=%h expected vld=1 fault=%0d kind=%0d pa=%h",
                     tag, extra, rsp_vld, rsp_fault, rsp_kind, rsp_pa, ef, ek, epa);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    localparam logic [11:0] ALL = 12'hFFF;
    localparam logic [63:0] VA_BIG = 64'h0000_0512_3456_789A; // bits 42..41 = 10
    localparam logic [63:0] VA_SML = 64'h0000_07FF_8123_4567; // bits 42..30 = 1FFE

    initial begin
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (rsp_vld !== 0 || rsp_fault !== 0 || rsp_kind !== 0 || rsp_pa !== 0) begin
            bad++;
            $display("FAIL R11 reset: vld=%b fault=%0d kind=%0d pa=%h expected all zero",
                     rsp_vld, rsp_fault, rsp_kind, rsp_pa);
        end
        rst_n = 1'b1;

        // R1: malformed upper bits, even inside an enabled window
        step(1, 0, 64'h0001_0000_0000_1000, 12'h011, 0, 2'b11, 1, 28'h1, ALL, "R1");
        step(1, 1, 64'hFFF0_0512_3456_789A, 12'h000, 0, 2'b11, 1, 28'h1, ALL, "R1");
        // sign-extended all-ones address is legal
        step(1, 0, 64'hFFFF_F800_0000_2345, 12'h011, 0, 2'b00, 1, 28'hABCDEF1, ALL, "R10");
        // R2 / R3 kernel windows, buffer response ignored
        step(1, 0, VA_BIG, 12'h011, 0, 2'b10, 0, 28'h0, 12'h000, "R2");
        step(1, 1, VA_SML, 12'h000, 0, 2'b01, 0, 28'h0, 12'h000, "R3");
        // R4 non-kernel
        step(1, 0, VA_BIG, 12'h011, 3, 2'b10, 1, 28'h5, ALL, "R4");
        step(1, 1, VA_SML, 12'h000, 1, 2'b01, 1, 28'h5, ALL, "R4");
        // R5 disabled windows go to the buffer
        step(1, 0, VA_BIG, 12'h011, 0, 2'b01, 1, 28'h0123456, ALL, "R5");
        step(1, 0, VA_SML, 12'h011, 2, 2'b10, 0, 28'h0, ALL, "R5");
        step(0, 0, '0, '0, 0, 0, 0, '0, '0, "R11");
        // R6 miss
        step(1, 1, 64'h0000_0000_1234_5000, 12'h000, 0, 2'b11, 0, 28'h7, ALL, "R6");
        // R7 ranking, one class removed at a time
        step(1, 0, 64'h2000, 12'h011, 0, 0, 1, 28'h9, 12'hFEF, "R7 acv");
        step(1, 0, 64'h2000, 12'h013, 0, 0, 1, 28'h9, 12'hFFC, "R7 foa");
        step(1, 0, 64'h2000, 12'h013, 0, 0, 1, 28'h9, 12'hFFE, "R7 tnv");
        step(1, 0, 64'h2000, 12'h113, 0, 0, 1, 28'h9, 12'h0F0, "R7 acv over foa");
        // R8 fetch ignores data need input, uses mode-indexed read enable
        step(1, 1, 64'h4321, 12'hFFF, 2, 0, 1, 28'h33, 12'h049, "R8");
        step(1, 1, 64'h4321, 12'h000, 2, 0, 1, 28'h33, 12'h029, "R8");
        step(1, 1, 64'h4321, 12'h000, 2, 0, 1, 28'h33, 12'h041, "R8 fe");
        // R9 data write kind on success and on fault
        step(1, 0, 64'h8765, 12'h105, 0, 0, 1, 28'h44, ALL, "R9");
        step(1, 0, 64'h8765, 12'h205, 1, 0, 0, 28'h44, ALL, "R9");
        step(0, 0, '0, '0, 0, 0, 0, '0, '0, "R11");

        for (int i = 0; i < 2000; i++) begin
            logic [63:0] va;
            logic [11:0] need, perm;
            int m, c;
            bit fe;
            va = {$urandom, $urandom};
            c  = $urandom % 5;
            m  = $urandom % 4;
            fe = $urandom % 2;
            if (c == 0) va[63:43] = 21'h0;
            if (c == 1) begin va[63:43] = 21'h0; va[42:41] = 2'b10; end
            if (c == 2) begin va[63:43] = '1; va[42:30] = 13'h1FFE; end
            if (c == 3) va[63:43] = 21'h1F_FFFF;
            if (m == 0 && ($urandom % 2)) m = 0;
            need = ($urandom % 2) ? 12'(1 | 2 | (1 << (4 + m))) : 12'(1 | 4 | (1 << (8 + m)));
            perm = ($urandom % 2) ? ALL : (ALL & ~(12'h1 << ($urandom % 12)));
            step(($urandom % 8) != 0, fe, va, need, 2'(m), 2'($urandom), ($urandom % 4) != 0,
                 28'($urandom), perm, "random");
        end
        finish_run();
    end

endmodule